// File: doc/BRIEF.md
# Time Slot Assigner Memory with Self-Filling Initialiser

This block holds one configuration word for each of 32 time slots and gives software access to them through two registers. The address register selects a slot, chooses between a read and a write command and carries an initialise flag. The data register supplies the word for a write, and receives the word fetched by a read. Software issues a single-entry command by writing the address register with the initialise flag clear. The word moves between the data register and the selected entry on that same clock edge.

While the initialise flag is set, a hardware walker owns the memory. It writes one entry per clock in ascending slot order and wraps back to slot 0 after slot 31. Each entry receives the attribute bits of the data register, but its low channel field is replaced by that entry's own slot number. For as long as the flag stays set, the reset output to the attached channel controllers is held active. The flag comes out of reset set, so every reset starts a fill. The fill only ends when software writes the address register with the flag clear. A one-cycle pulse marks the end of each complete pass over the memory.

Top module: `tsa_init_top`

## Requirements
- R1: After reset the address register reads 0x0100: slot 0, read bit clear, initialise flag (bit 8) set.
- R2: While the flag is set, the walker writes entries 0,1,...,31 one per clock and then wraps to 0. Each entry gets data register bits [15:5] and has bits [4:0] equal to its own slot index.
- R3: Data register writes made while the walker runs are picked up by later passes. One full pass after such a write, every entry carries the new attribute bits.
- R4: Writing the address register with bit 8 clear stops the walker from the next cycle. After that, no entry changes except through explicit write commands.
- R5: The controller reset output is high exactly while the initialise flag is set. It changes only on writes to the address register.
- R6: The done output pulses high for one cycle, in the cycle after entry 31 has been written. While the walker runs, successive pulses are 32 cycles apart.
- R7: With the flag clear, an address register write with bit 8 = 0 and bit 5 = 0 stores the current data register word into the entry named by bits [4:0].
- R8: With the flag clear, an address register write with bit 8 = 0 and bit 5 = 1 loads the entry named by bits [4:0] into the data register on that edge.
- R9: Commands are blocked while the walker is active. This includes the write that clears the flag: it stops the walker but reads or writes no entry and leaves the data register unchanged. A write that sets the flag (re)starts a fill at entry 0 and performs no access, so its first done pulse arrives 32 cycles later.
- R10: The address register reads back the written slot in bits [4:0], the read bit in bit 5 and the flag in bit 8. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regSel | input | 1 | Register select: 0 = address register, 1 = data register |
| regWrData | input | 16 | Write data for the selected register |
| addrRegOut | output | 16 | Address register contents |
| dataRegOut | output | 16 | Data register contents (read results land here) |
| ctrlRst | output | 1 | Reset to the attached channel controllers, high while initialising |
| passDone | output | 1 | One-cycle pulse after each complete fill pass |

## Verification
The bench builds the block with its default sizes: 32 slots, 16-bit entries and a 5-bit channel field. With a memory this shallow, every entry can be read back after each fill, and a full pass of 32 cycles is short enough to time done pulses exactly. The bench changes the data register in the middle of a fill and checks that the new attribute bits reach every entry. It also times a restart from an idle state to its first done pulse. Finally, it issues a read command that also clears the flag during a fill, to show that the command is blocked.

// File: rtl/tsa_init_pkg.sv
`timescale 1ns/1ps
package tsa_init_pkg;
  localparam int SLOTS    = 32;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int REG_W    = 16;
  localparam int ENTRY_W  = 16;
  localparam int CH_W     = SLOT_W;
  localparam int RD_POS   = 5;
  localparam int INIT_POS = 8;
  localparam logic [REG_W-1:0] ADDR_RST = REG_W'(1) << INIT_POS;

  // strobes from control to datapath
  typedef struct packed {
    logic              memWe;
    logic              fillSel;
    logic              rdLoad;
    logic [SLOT_W-1:0] memAddr;
  } tsaStrobe_t;
endpackage

// File: rtl/tsa_init_ctrl.sv
`timescale 1ns/1ps
module tsa_init_ctrl
  import tsa_init_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrWr,
  input  logic [SLOT_W-1:0]    wrSlot,
  input  logic                 wrRead,
  input  logic                 wrInit,
  output tsaStrobe_t           strobe,
  output logic [REG_W-1:0]     addrRegOut,
  output logic                 initActive,
  output logic                 passDone
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slotQ;
  logic [SLOT_W-1:0] ptrQ;
  logic              readQ;
  logic              initQ;
  logic              doneQ;
  logic              cmdGo;

  // a command reaches the memory only when the walker is idle and stays idle
  assign cmdGo = addrWr && !initQ && !wrInit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotQ <= ADDR_RST[SLOT_W-1:0];
      readQ <= ADDR_RST[RD_POS];
      initQ <= ADDR_RST[INIT_POS];
      ptrQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= initQ && (ptrQ == LAST);
      if (initQ) begin
        ptrQ <= (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
      end else begin
        ptrQ <= '0;
      end
      if (addrWr) begin
        slotQ <= wrSlot;
        readQ <= wrRead;
        initQ <= wrInit;
      end
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.fillSel = initQ;
    if (initQ) begin
      strobe.memWe   = 1'b1;
      strobe.memAddr = ptrQ;
    end else begin
      strobe.memAddr = wrSlot;
      strobe.memWe   = cmdGo && !wrRead;
      strobe.rdLoad  = cmdGo && wrRead;
    end
  end

  always_comb begin
    addrRegOut                 = '0;
    addrRegOut[SLOT_W-1:0]     = slotQ;
    addrRegOut[RD_POS]         = readQ;
    addrRegOut[INIT_POS]       = initQ;
  end

  assign initActive = initQ;
  assign passDone   = doneQ;
endmodule

// File: rtl/tsa_init_dpath.sv
`timescale 1ns/1ps
module tsa_init_dpath
  import tsa_init_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               dataWr,
  input  logic [REG_W-1:0]   wrData,
  input  tsaStrobe_t         strobe,
  output logic [ENTRY_W-1:0] dataRegOut
);
  logic [ENTRY_W-1:0] memQ [SLOTS];
  logic [ENTRY_W-1:0] dataQ;
  logic [ENTRY_W-1:0] wrWord;

  // fill writes substitute the slot index into the channel field
  always_comb begin
    wrWord = dataQ;
    if (strobe.fillSel) begin
      wrWord[CH_W-1:0] = strobe.memAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.memWe) begin
      memQ[strobe.memAddr] <= wrWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (dataWr) begin
      dataQ <= ENTRY_W'(wrData);
    end else if (strobe.rdLoad) begin
      dataQ <= memQ[strobe.memAddr];
    end
  end

  assign dataRegOut = dataQ;
endmodule

// File: rtl/tsa_init_top.sv
`timescale 1ns/1ps
module tsa_init_top
  import tsa_init_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regSel,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     addrRegOut,
  output logic [ENTRY_W-1:0]   dataRegOut,
  output logic                 ctrlRst,
  output logic                 passDone
);
  tsaStrobe_t strobe;
  logic       initActive;

  tsa_init_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrWr     (regWrEn && !regSel),
    .wrSlot     (regWrData[SLOT_W-1:0]),
    .wrRead     (regWrData[RD_POS]),
    .wrInit     (regWrData[INIT_POS]),
    .strobe     (strobe),
    .addrRegOut (addrRegOut),
    .initActive (initActive),
    .passDone   (passDone)
  );

  tsa_init_dpath uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .dataWr     (regWrEn && regSel),
    .wrData     (regWrData),
    .strobe     (strobe),
    .dataRegOut (dataRegOut)
  );

  assign ctrlRst = initActive;
endmodule

// File: rtl/tsa_init_chk.sv
`timescale 1ns/1ps
module tsa_init_chk
  import tsa_init_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regSel,
  input logic [SLOT_W-1:0]  wrSlot,
  input logic               wrInit,
  input logic [SLOT_W-1:0]  addrSlot,
  input logic [ENTRY_W-1:0] dataRegOut,
  input logic               ctrlRst,
  input logic               passDone
);
  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && !wrInit) |=> !ctrlRst);

  a_r9_restart_sets: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel && wrInit) |=> ctrlRst);

  a_r5_only_addr_write: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && !regSel) |=> $stable(ctrlRst));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    passDone |=> !passDone);

  a_r6_done_after_fill: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> $past(ctrlRst));

  a_r9_no_load_in_init: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRst && !(regWrEn && regSel)) |=> $stable(dataRegOut));

  a_r10_slot_follows: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regSel) |=> (addrSlot == $past(wrSlot)));
endmodule

bind tsa_init_top tsa_init_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regSel     (regSel),
  .wrSlot     (regWrData[tsa_init_pkg::SLOT_W-1:0]),
  .wrInit     (regWrData[tsa_init_pkg::INIT_POS]),
  .addrSlot   (addrRegOut[tsa_init_pkg::SLOT_W-1:0]),
  .dataRegOut (dataRegOut),
  .ctrlRst    (ctrlRst),
  .passDone   (passDone)
);

// File: tb/tb_tsa_init_top.sv
`timescale 1ns/1ps
module tb_tsa_init_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] addrRegOut;
  logic [15:0] dataRegOut;
  logic        ctrlRst;
  logic        passDone;

  tsa_init_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .addrRegOut(addrRegOut), .dataRegOut(dataRegOut),
    .ctrlRst(ctrlRst), .passDone(passDone)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];
  string tagQ[$];
  logic sawRd = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the capturing edge
  task automatic regWrite(bit sel, logic [15:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readEntry(int slot, logic [15:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regWrite(1'b0, 16'h0020 | 16'(slot));
  endtask

  task automatic cyclesToDone(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!passDone && n < 100);
  endtask

  // monitor: every read command yields one data register value to compare
  always @(posedge clk) sawRd <= regWrEn && !regSel && regWrData[5];
  always @(negedge clk) begin
    if (sawRd) begin
      if (expQ.size() == 0) begin
        check("R8 unexpected read", 32'd1, 32'd0);
      end else begin
        check(tagQ.pop_front(), 32'(dataRegOut), 32'(expQ.pop_front()));
      end
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 addr reset", 32'(addrRegOut), 32'h0100);
    check("R5 reset held after reset", 32'(ctrlRst), 32'd1);

    // R3: data register written while the fill runs
    regWrite(1'b1, 16'hA5E0);
    cyclesToDone(n);
    cyclesToDone(n);
    check("R6 pass spacing", 32'(n), 32'd32);
    @(negedge clk);
    check("R6 pulse width", 32'(passDone), 32'd0);

    // R4/R9: stop with a blocked write to slot 0
    regWrite(1'b0, 16'h0000);
    check("R4 stop clears reset", 32'(ctrlRst), 32'd0);
    check("R10 addr after stop", 32'(addrRegOut), 32'h0000);
    check("R9 stop write no data change", 32'(dataRegOut), 32'hA5E0);
    for (int i = 0; i < 32; i++) begin
      readEntry(i, 16'hA5E0 | 16'(i), "R2 fill entry");
    end

    // R7 write command, R4 no refill after stop
    regWrite(1'b1, 16'h1234);
    regWrite(1'b0, 16'h0007);
    check("R10 addr write cmd", 32'(addrRegOut), 32'h0007);
    readEntry(7, 16'h1234, "R7 written entry");
    check("R10 addr read cmd", 32'(addrRegOut), 32'h0027);
    readEntry(6, 16'hA5E6, "R4 untouched entry");
    readEntry(0, 16'hA5E0, "R9 blocked stop write");

    // R9 restart from entry 0
    regWrite(1'b1, 16'hC3E0);
    regWrite(1'b0, 16'h0103);
    check("R5 restart reset", 32'(ctrlRst), 32'd1);
    cyclesToDone(n);
    check("R9 restart first done", 32'(n), 32'd32);

    // R3 pick up a change mid-fill
    regWrite(1'b1, 16'h3C00);
    repeat (40) @(negedge clk);
    readEntry(2, 16'h3C00, "R9 blocked read");
    check("R4 read stops fill", 32'(ctrlRst), 32'd0);
    for (int i = 0; i < 32; i++) begin
      readEntry(i, 16'h3C00 | 16'(i), "R3 refill entry");
    end
    repeat (3) @(negedge clk);
    check("R6 no done when idle", 32'(passDone), 32'd0);
    check("R8 queue drained", 32'(expQ.size()), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule